// File: doc/BRIEF.md
# USB Handshake Interrupt Filter

This block sits between a USB device serial interface engine and a host microprocessor. Each clock the engine may present one handshake event: an ACK, NAK or NYET, tagged with an endpoint number and a direction. The block decides whether that event is worth an interrupt, records a pending flag for the endpoint and direction, and drives a single interrupt pin towards the processor.

The decision depends on a 2-bit mode. There is one mode for control endpoint 0, one for the data IN endpoints and one for the data OUT endpoints. One of the modes reports only the first NAK seen after an ACK. To support it, the block keeps one bit of NAK history per endpoint and direction.

An 8-bit configuration byte holds the three modes, a signalling select (level or pulse) and the pin polarity. Software reads and writes it over a simple write-strobe bus. The per-endpoint enables and the global enable come from elsewhere in the register map. The pending flags are cleared by writing ones.

Top module: `hsk_irq_filter`

## Requirements
- R1: After power-on reset the configuration byte reads 0x03 on `cfg_rdata`, and `cfg_rdata` always shows the current byte.
- R2: A `cfg_wr` strobe replaces the whole byte on the next edge. A `bus_reset` pulse zeroes bits 7:2 and keeps bits 1:0. It takes priority over a write in the same cycle.
- R3: Events on endpoint 0 use mode bits 7:6. Events on endpoints 1 to 7 use bits 5:4 when `evt_dir`=1 (IN, device transmits) and bits 3:2 when `evt_dir`=0 (OUT, device receives).
- R4: An ACK (`evt_code`=00) sets the pending flag of its endpoint and direction in every mode.
- R5: A NYET (`evt_code`=10) sets a pending flag only for OUT events on endpoints 1 to 7, in every mode. It never does so on endpoint 0 or on IN events.
- R6: A NAK (`evt_code`=01) sets the pending flag as follows:
  - mode 00: always;
  - mode 01: never;
  - modes 10 and 11: only when no NAK has been seen on that endpoint and direction since the last ACK there.
  The NAK history is set by any NAK, cleared by an ACK, and cleared by reset and by `bus_reset`.
- R7: Pending flags land in `pend_tx[ep]` for IN events and `pend_rx[ep]` for OUT events, one edge after the event. A `clr_wr` strobe clears the flags whose bits are 1 in `clr_rx`/`clr_tx`. A flag set and cleared in the same cycle stays set.
- R8: With bit 1 = 0 (level), the interrupt is active while `glob_en` is 1 and some pending flag has its enable bit (`rx_en`/`tx_en`) set.
- R9: With bit 1 = 1 (pulse), an accepted event is a trigger when its endpoint enable bit and `glob_en` are 1. A trigger makes the interrupt active for exactly PULSE_CYC cycles. A trigger during a pulse restarts the count.
- R10: With bit 0 = 1 the pin equals the active state (active high). With bit 0 = 0 it is the inverse (active low).
- R11: Events with `evt_valid`=0, and events with the reserved code 11, change no pending flag and no NAK history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_reset | input | 1 | USB bus reset pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current configuration byte |
| evt_valid | input | 1 | Handshake event present |
| evt_code | input | 2 | 00 ACK, 01 NAK, 10 NYET, 11 reserved |
| evt_ep | input | EPW | Endpoint number |
| evt_dir | input | 1 | 1 = IN, 0 = OUT |
| rx_en | input | N_EP | Per-endpoint OUT interrupt enables |
| tx_en | input | N_EP | Per-endpoint IN interrupt enables |
| glob_en | input | 1 | Global interrupt enable |
| clr_wr | input | 1 | Pending clear strobe |
| clr_rx | input | N_EP | OUT pending bits to clear |
| clr_tx | input | N_EP | IN pending bits to clear |
| pend_rx | output | N_EP | OUT pending flags |
| pend_tx | output | N_EP | IN pending flags |
| int_pin | output | 1 | Interrupt pin to the processor |

## Verification
The hardest situation to reach is the first-NAK mode after its history has been disturbed. Examples are a NAK arriving on the other direction of the same endpoint, an ACK landing in the same cycle as a bus reset, and mode changes between NAKs. The NAK history is invisible at the ports. The bench reaches these cases with directed sequences that alternate ACK and NAK on one endpoint in both directions. It then runs a long random mix of events, writes, clears, enable changes and bus resets. A behavioural model predicts every pending flag and the pin level on every cycle.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [1:0] {
    HS_ACK  = 2'b00,
    HS_NAK  = 2'b01,
    HS_NYET = 2'b10,
    HS_RSVD = 2'b11
  } hs_code_e;

  // configuration byte, MSB first
  typedef struct packed {
    logic [1:0] ctl_mode;
    logic [1:0] in_mode;
    logic [1:0] out_mode;
    logic       pulse_sel;
    logic       pol_hi;
  } cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h03;

  // pick the mode field that governs an event
  function automatic logic [1:0] mode_for(cfg_t c, logic is_ctrl, logic dir_in);
    logic [1:0] m;
    if (is_ctrl)     m = c.ctl_mode;
    else if (dir_in) m = c.in_mode;
    else             m = c.out_mode;
    return m;
  endfunction

  // does a handshake raise an interrupt under a mode
  function automatic logic hs_accept(logic [1:0] mode, hs_code_e code,
                                     logic is_ctrl, logic dir_in, logic nak_seen);
    logic r;
    r = 1'b0;
    case (code)
      HS_ACK:  r = 1'b1;
      HS_NYET: r = !is_ctrl && !dir_in;
      HS_NAK: begin
        case (mode)
          2'b00:   r = 1'b1;
          2'b01:   r = 1'b0;
          default: r = !nak_seen;
        endcase
      end
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hsk_cfg_reg.sv
module hsk_cfg_reg
  import hsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       wr,
  input  logic [7:0] wdata,
  output cfg_t       cfg
);

  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= cfg_t'(CFG_RESET);
    else if (bus_reset) cfg_q <= cfg_t'({6'b0, cfg_q.pulse_sel, cfg_q.pol_hi});
    else if (wr)        cfg_q <= cfg_t'(wdata);
  end

  assign cfg = cfg_q;

  // R2: a bus reset clears the modes and keeps the signalling bits
  p_busrst_keeps_sig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (cfg_q[7:2] == 6'b0) && (cfg_q[1:0] == $past(cfg_q[1:0])));

endmodule

// File: rtl/hsk_nak_track.sv
module hsk_nak_track
  import hsk_pkg::*;
#(
  parameter int N_EP = 8,
  localparam int EPW = $clog2(N_EP)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            upd,
  input  logic            is_ack,
  input  logic            is_nak,
  input  logic [EPW-1:0]  ep,
  input  logic            dir_in,
  output logic [N_EP-1:0] seen_in,
  output logic [N_EP-1:0] seen_out
);

  for (genvar g = 0; g < N_EP; g++) begin : g_ep
    logic hit_in, hit_out;
    assign hit_in  = upd && (ep == EPW'(g)) && dir_in;
    assign hit_out = upd && (ep == EPW'(g)) && !dir_in;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  seen_in[g] <= 1'b0;
      else if (bus_reset)          seen_in[g] <= 1'b0;
      else if (hit_in && is_ack)   seen_in[g] <= 1'b0;
      else if (hit_in && is_nak)   seen_in[g] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  seen_out[g] <= 1'b0;
      else if (bus_reset)          seen_out[g] <= 1'b0;
      else if (hit_out && is_ack)  seen_out[g] <= 1'b0;
      else if (hit_out && is_nak)  seen_out[g] <= 1'b1;
    end
  end

  // R6: an ACK leaves the history of its endpoint and direction clear
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_ack) |=> ($past(dir_in) ? !seen_in[$past(ep)] : !seen_out[$past(ep)]));

  // R6: a NAK without bus reset marks the history
  p_nak_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_nak && !bus_reset) |=> ($past(dir_in) ? seen_in[$past(ep)] : seen_out[$past(ep)]));

endmodule

// File: rtl/hsk_pend.sv
module hsk_pend #(
  parameter int N_EP = 8
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EP-1:0] set_rx,
  input  logic [N_EP-1:0] set_tx,
  input  logic            clr_wr,
  input  logic [N_EP-1:0] clr_rx,
  input  logic [N_EP-1:0] clr_tx,
  output logic [N_EP-1:0] pend_rx,
  output logic [N_EP-1:0] pend_tx
);

  for (genvar g = 0; g < N_EP; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_rx[g] <= 1'b0;
        pend_tx[g] <= 1'b0;
      end else begin
        pend_rx[g] <= set_rx[g] | (pend_rx[g] & ~(clr_wr & clr_rx[g]));
        pend_tx[g] <= set_tx[g] | (pend_tx[g] & ~(clr_wr & clr_tx[g]));
      end
    end
  end

  // R7: cleared bits are gone unless set in the same cycle
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pend_rx & $past(clr_rx) & ~$past(set_rx)) == '0) &&
               ((pend_tx & $past(clr_tx) & ~$past(set_tx)) == '0));

endmodule

// File: rtl/hsk_int_drive.sv
module hsk_int_drive #(
  parameter int N_EP      = 8,
  parameter int PULSE_CYC = 3,
  localparam int CW = $clog2(PULSE_CYC + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [N_EP-1:0] pend_rx,
  input  logic [N_EP-1:0] pend_tx,
  input  logic [N_EP-1:0] rx_en,
  input  logic [N_EP-1:0] tx_en,
  input  logic            glob_en,
  input  logic            pulse_sel,
  input  logic            pol_hi,
  output logic            active,
  output logic            int_pin
);

  logic [CW-1:0] cnt_q;
  logic          lvl_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (fire)        cnt_q <= CW'(PULSE_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign lvl_act = glob_en && (|((pend_rx & rx_en) | (pend_tx & tx_en)));
  assign active  = pulse_sel ? (cnt_q != '0) : lvl_act;
  assign int_pin = pol_hi ? active : !active;

  // R9: a trigger reloads the full width
  p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == CW'(PULSE_CYC)));

  // R9: the count never exceeds the width and only falls by one
  p_pulse_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/hsk_irq_filter.sv
module hsk_irq_filter
  import hsk_pkg::*;
#(
  parameter int N_EP      = 8,
  parameter int PULSE_CYC = 3,
  localparam int EPW = $clog2(N_EP)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic            evt_valid,
  input  logic [1:0]      evt_code,
  input  logic [EPW-1:0]  evt_ep,
  input  logic            evt_dir,
  input  logic [N_EP-1:0] rx_en,
  input  logic [N_EP-1:0] tx_en,
  input  logic            glob_en,
  input  logic            clr_wr,
  input  logic [N_EP-1:0] clr_rx,
  input  logic [N_EP-1:0] clr_tx,
  output logic [N_EP-1:0] pend_rx,
  output logic [N_EP-1:0] pend_tx,
  output logic            int_pin
);

  cfg_t            cfg;
  hs_code_e        code;
  logic            is_ctrl, ev_ok, seen_sel, accept, ep_en, fire, active;
  logic [1:0]      mode;
  logic [N_EP-1:0] seen_in, seen_out, ep_hot, set_rx, set_tx;

  hsk_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .wr(cfg_wr), .wdata(cfg_wdata), .cfg(cfg)
  );

  assign cfg_rdata = cfg;

  // event decode
  assign code     = hs_code_e'(evt_code);
  assign ev_ok    = evt_valid && (code != HS_RSVD);
  assign is_ctrl  = (evt_ep == '0);
  assign mode     = mode_for(cfg, is_ctrl, evt_dir);
  assign seen_sel = evt_dir ? seen_in[evt_ep] : seen_out[evt_ep];
  assign accept   = ev_ok && hs_accept(mode, code, is_ctrl, evt_dir, seen_sel);
  assign ep_hot   = N_EP'(1) << evt_ep;
  assign set_rx   = (accept && !evt_dir) ? ep_hot : '0;
  assign set_tx   = (accept &&  evt_dir) ? ep_hot : '0;
  assign ep_en    = evt_dir ? tx_en[evt_ep] : rx_en[evt_ep];
  assign fire     = accept && ep_en && glob_en;

  hsk_nak_track #(.N_EP(N_EP)) u_nak (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .upd(ev_ok), .is_ack(code == HS_ACK), .is_nak(code == HS_NAK),
    .ep(evt_ep), .dir_in(evt_dir),
    .seen_in(seen_in), .seen_out(seen_out)
  );

  hsk_pend #(.N_EP(N_EP)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_rx(set_rx), .set_tx(set_tx),
    .clr_wr(clr_wr), .clr_rx(clr_rx), .clr_tx(clr_tx),
    .pend_rx(pend_rx), .pend_tx(pend_tx)
  );

  hsk_int_drive #(.N_EP(N_EP), .PULSE_CYC(PULSE_CYC)) u_drv (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .pend_rx(pend_rx), .pend_tx(pend_tx), .rx_en(rx_en), .tx_en(tx_en),
    .glob_en(glob_en), .pulse_sel(cfg.pulse_sel), .pol_hi(cfg.pol_hi),
    .active(active), .int_pin(int_pin)
  );

  // R4: an ACK always lands in the pending flags
  p_ack_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 2'b00) |=>
      ($past(evt_dir) ? pend_tx[$past(evt_ep)] : pend_rx[$past(evt_ep)]));

  // R11: reserved codes leave the pending flags untouched
  p_rsvd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 2'b11 && !clr_wr) |=>
      (pend_rx == $past(pend_rx)) && (pend_tx == $past(pend_tx)));

  // R5: NYET on endpoint 0 never sets a pending flag
  p_nyet_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 2'b10 && evt_ep == '0 && !clr_wr) |=>
      (pend_rx[0] == $past(pend_rx[0])) && (pend_tx[0] == $past(pend_tx[0])));

endmodule

// File: tb/hsk_irq_filter_tb.sv
`timescale 1ns/1ps
module hsk_irq_filter_tb;

  localparam int NE = 8;
  localparam int P  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       evt_valid = 1'b0;
  logic [1:0] evt_code = 2'b00;
  logic [2:0] evt_ep = 3'd0;
  logic       evt_dir = 1'b0;
  logic [NE-1:0] rx_en = '1, tx_en = '1;
  logic       glob_en = 1'b1;
  logic       clr_wr = 1'b0;
  logic [NE-1:0] clr_rx = '0, clr_tx = '0;
  logic [NE-1:0] pend_rx, pend_tx;
  logic       int_pin;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  hsk_irq_filter #(.N_EP(NE), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_ep(evt_ep), .evt_dir(evt_dir),
    .rx_en(rx_en), .tx_en(tx_en), .glob_en(glob_en),
    .clr_wr(clr_wr), .clr_rx(clr_rx), .clr_tx(clr_tx),
    .pend_rx(pend_rx), .pend_tx(pend_tx), .int_pin(int_pin)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [7:0]    m_cfg;
  logic [NE-1:0] m_prx, m_ptx, m_nin, m_nout;
  int            m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 8'h03; m_prx = '0; m_ptx = '0; m_nin = '0; m_nout = '0; m_cnt = 0;
    end else begin
      logic [1:0] md;
      logic take, hist, en;
      take = 1'b0;
      hist = evt_dir ? m_nin[evt_ep] : m_nout[evt_ep];
      if (evt_ep == 0) md = m_cfg[7:6];
      else md = evt_dir ? m_cfg[5:4] : m_cfg[3:2];
      if (evt_valid) begin
        if (evt_code == 2'd0) take = 1'b1;
        else if (evt_code == 2'd2) take = (evt_ep != 0) && !evt_dir;
        else if (evt_code == 2'd1) take = (md == 2'd0) ? 1'b1 : (md == 2'd1) ? 1'b0 : !hist;
      end
      en = evt_dir ? tx_en[evt_ep] : rx_en[evt_ep];
      if (take && en && glob_en) m_cnt = P;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (clr_wr) begin m_prx = m_prx & ~clr_rx; m_ptx = m_ptx & ~clr_tx; end
      if (take) begin
        if (evt_dir) m_ptx[evt_ep] = 1'b1; else m_prx[evt_ep] = 1'b1;
      end
      if (evt_valid && evt_code == 2'd0) begin
        if (evt_dir) m_nin[evt_ep] = 1'b0; else m_nout[evt_ep] = 1'b0;
      end else if (evt_valid && evt_code == 2'd1) begin
        if (evt_dir) m_nin[evt_ep] = 1'b1; else m_nout[evt_ep] = 1'b1;
      end
      if (bus_reset) begin m_nin = '0; m_nout = '0; m_cfg = {6'b0, m_cfg[1:0]}; end
      else if (cfg_wr) m_cfg = cfg_wdata;
    end
  end

  function automatic logic exp_pin();
    logic act;
    if (m_cfg[1]) act = (m_cnt != 0);
    else act = glob_en && (((m_prx & rx_en) | (m_ptx & tx_en)) != '0);
    return m_cfg[0] ? act : !act;
  endfunction

  task automatic cmp_model();
    logic ep;
    ep = exp_pin();
    total++;
    if (int_pin !== ep || pend_rx !== m_prx || pend_tx !== m_ptx || cfg_rdata !== m_cfg) begin
      bad++;
      $display("FAIL %s model: pin=%b/%b rx=%h/%h tx=%h/%h cfg=%h/%h", cur_req,
               int_pin, ep, pend_rx, m_prx, pend_tx, m_ptx, cfg_rdata, m_cfg);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    if (rst_n) cmp_model();
  endtask

  task automatic ev(logic [1:0] c, int ep, logic d);
    evt_code = c; evt_ep = 3'(ep); evt_dir = d; evt_valid = 1'b1;
    tick();
    evt_valid = 1'b0;
  endtask

  task automatic wcfg(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; tick(); cfg_wr = 1'b0;
  endtask

  task automatic clr_all();
    clr_wr = 1'b1; clr_rx = '1; clr_tx = '1; tick();
    clr_wr = 1'b0; clr_rx = '0; clr_tx = '0;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    chk("R1", cfg_rdata, 8'h03);
    chk("R10", int_pin, 1'b0);

    cur_req = "R2";
    wcfg(8'h00);                       // level, active low, modes 00
    chk("R2", cfg_rdata, 8'h00);
    chk("R10", int_pin, 1'b1);

    cur_req = "R4";
    ev(2'b00, 3, 1'b1);
    chk("R4", pend_tx, 8'h08);
    chk("R8", int_pin, 1'b0);
    clr_wr = 1'b1; clr_tx = 8'h08; tick(); clr_wr = 1'b0; clr_tx = '0;
    chk("R7", pend_tx, 8'h00);
    chk("R10", int_pin, 1'b1);

    cur_req = "R5";
    ev(2'b10, 0, 1'b0);
    chk("R5", pend_rx, 8'h00);
    ev(2'b10, 2, 1'b1);
    chk("R5", pend_tx, 8'h00);
    ev(2'b10, 2, 1'b0);
    chk("R5", pend_rx, 8'h04);
    clr_all();

    cur_req = "R3";
    wcfg(8'h90);                       // ctl 10, in 01, out 00
    ev(2'b01, 0, 1'b0);
    chk("R6", pend_rx, 8'h01);
    clr_all();
    ev(2'b01, 0, 1'b0);
    chk("R6", pend_rx, 8'h00);
    ev(2'b01, 4, 1'b1);
    chk("R3", pend_tx, 8'h00);
    ev(2'b01, 4, 1'b0);
    chk("R3", pend_rx, 8'h10);
    clr_all();
    ev(2'b00, 0, 1'b0);
    clr_all();
    ev(2'b01, 0, 1'b0);
    chk("R6", pend_rx, 8'h01);
    ev(2'b01, 0, 1'b1);
    chk("R6", pend_tx, 8'h01);
    clr_all();

    cur_req = "R2";
    bus_reset = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'hFF; tick();
    bus_reset = 1'b0; cfg_wr = 1'b0;
    chk("R2", cfg_rdata, 8'h00);
    wcfg(8'h5A);
    chk("R2", cfg_rdata, 8'h5A);
    bus_reset = 1'b1; tick(); bus_reset = 1'b0;
    chk("R2", cfg_rdata, 8'h02);

    cur_req = "R7";
    clr_wr = 1'b1; clr_rx = '1; clr_tx = '1;
    ev(2'b00, 1, 1'b0);
    clr_wr = 1'b0; clr_rx = '0; clr_tx = '0;
    chk("R7", pend_rx, 8'h02);
    clr_all();

    cur_req = "R8";
    wcfg(8'h01);
    ev(2'b00, 5, 1'b1);
    chk("R8", int_pin, 1'b1);
    tx_en[5] = 1'b0; tick();
    chk("R8", int_pin, 1'b0);
    tx_en[5] = 1'b1; glob_en = 1'b0; tick();
    chk("R8", int_pin, 1'b0);
    glob_en = 1'b1; tick();
    chk("R8", int_pin, 1'b1);
    clr_all();
    chk("R8", int_pin, 1'b0);

    cur_req = "R9";
    wcfg(8'h03);
    ev(2'b00, 6, 1'b0);
    n = 0;
    while (int_pin && n < 20) begin n++; tick(); end
    chk("R9", n, P);
    ev(2'b00, 6, 1'b0);
    tick();
    ev(2'b00, 6, 1'b0);
    n = 0;
    while (int_pin && n < 20) begin n++; tick(); end
    chk("R9", n, P);
    rx_en[6] = 1'b0;
    ev(2'b00, 6, 1'b0);
    chk("R9", int_pin, 1'b0);
    chk("R9", pend_rx[6], 1'b1);
    rx_en[6] = 1'b1;
    clr_all();

    cur_req = "R11";
    wcfg(8'h00);
    ev(2'b11, 1, 1'b0);
    chk("R11", pend_rx, 8'h00);
    evt_code = 2'b00; evt_ep = 3'd1; evt_dir = 1'b0; evt_valid = 1'b0; tick();
    chk("R11", pend_rx, 8'h00);

    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      evt_valid = ($urandom % 2) == 0;
      evt_code  = 2'($urandom);
      evt_ep    = 3'($urandom);
      evt_dir   = 1'($urandom);
      cfg_wr    = ($urandom % 25) == 0;
      cfg_wdata = 8'($urandom);
      clr_wr    = ($urandom % 8) == 0;
      clr_rx    = 8'($urandom);
      clr_tx    = 8'($urandom);
      bus_reset = ($urandom % 60) == 0;
      if (($urandom % 20) == 0) rx_en = 8'($urandom);
      if (($urandom % 20) == 0) tx_en = 8'($urandom);
      if (($urandom % 30) == 0) glob_en = ~glob_en;
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule